// File: doc/BRIEF.md
# Rate-Matching Idle Insert/Delete FIFO

This block is a receive-side elastic buffer for a 32-bit, four-lane column stream. Each column holds four data bytes and one control flag per lane. Lane 0 occupies data bits 7:0 and flag bit 0, and lane n occupies bits 8n+7:8n and flag bit n. Columns come in on a write strobe and leave on a read enable. When the write side runs faster than the read side, the buffer fills and the block drops removable columns. When the read side runs faster, the buffer drains and the block adds idle columns. Both actions follow packet framing rules, so a frame is never cut or padded and the idles right after the end of a frame stay intact.

The fill thresholds are input ports, so the system can set them at run time. Four saturating counters report how many columns were added, how many were removed, how many writes were lost to a full buffer and how many reads found it empty. The write and read strobes share one clock. The rate mismatch shows up as the pattern of those strobes.

Column codes: an idle column has all four flags set and every byte equal to 0x07. A sequence column has only flag 0 set and 0x9C in lane 0. A signal column has only flag 0 set and 0x5C in lane 0. A start column has flag 0 set and 0xFB in lane 0. A terminate is any lane whose flag is set and whose byte is 0xFD.

Top module: `rate_match_fifo`

## Requirements
- R1: After reset, fill reads 0, rd_valid is low and all four counters read 0.
- R2: Columns that are neither removed nor lost leave in write order. rd_valid and the registered read column appear on the clock edge after the one that samples rd_en. fill gives the stored column count after each edge.
- R3: A written idle column is discarded when fill is above hi_mark at that edge. Each discard increments del_count.
- R4: The column written directly after a column that contains a terminate in any lane is never discarded.
- R5: When fill is above hi_mark, a sequence column is discarded only if the column written just before it was a sequence column that was kept. A run of three sequence columns therefore loses only the middle one.
- R6: Signal columns and data columns are never discarded, whatever the fill.
- R7: On a read with fill below lo_mark, an idle column is emitted without popping, and ins_count increments. This happens only if the last emitted column was idle, sequence or signal and no frame is open.
- R8: After a start column has been emitted and before a column with a terminate has been emitted, no idle column is inserted.
- R9: A write of a non-removable column while fill equals the depth (16) is lost, increments ovf_count, and leaves fill at 16.
- R10: A read with the buffer empty and no insertion allowed emits an idle column and increments udf_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write column strobe |
| wr_data | input | 32 | Write column bytes, lane 0 in bits 7:0 |
| wr_ctrl | input | 4 | Write column control flags, lane n in bit n |
| rd_en | input | 1 | Request one column on the read side |
| hi_mark | input | 5 | Fill above which columns are removed |
| lo_mark | input | 5 | Fill below which idles are added |
| rd_valid | output | 1 | Read column valid, one cycle after rd_en |
| rd_data | output | 32 | Read column bytes |
| rd_ctrl | output | 4 | Read column control flags |
| fill | output | 5 | Stored column count |
| ins_count | output | 16 | Saturating count of inserted idles |
| del_count | output | 16 | Saturating count of removed columns |
| ovf_count | output | 16 | Saturating count of writes lost to a full buffer |
| udf_count | output | 16 | Saturating count of reads on an empty buffer |

## Verification
The bench drives idle columns above the high threshold both right after a terminate column and one column later. A design that ignored the protection would drop the first idle of the gap and fill would come out one short. It sends three sequence columns in a row followed by two signal columns. Removing every sequence column, or thinning signal columns, would change both fill and the removal count. It opens a frame and drains the buffer below the low threshold, where a careless insert would pad the frame and a wrong emptiness test would miss the underflow. A long random phase with a reference queue model catches ordering, latency and counter drift, and a write burst past full checks that nothing stored is overwritten.

// File: rtl/rmf_pkg.sv
package rmf_pkg;
    localparam logic [7:0] IDLE_BYTE  = 8'h07;
    localparam logic [7:0] TERM_BYTE  = 8'hFD;
    localparam logic [7:0] START_BYTE = 8'hFB;
    localparam logic [7:0] SEQ_BYTE   = 8'h9C;
    localparam logic [7:0] SIG_BYTE   = 8'h5C;
    localparam int         LANES      = 4;

    typedef struct packed {
        logic [LANES-1:0]   ctrl;
        logic [8*LANES-1:0] data;
    } col_t;

    typedef struct packed {
        logic idle;
        logic seq;
        logic sig;
        logic term;
        logic start;
    } cls_t;

    localparam col_t IDLE_COL = '{ctrl: {LANES{1'b1}}, data: {LANES{IDLE_BYTE}}};
endpackage

// File: rtl/rmf_classify.sv
module rmf_classify
    import rmf_pkg::*;
(
    input  col_t col,
    output cls_t cls
);
    logic [LANES-1:0] lane_term;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_term[g] = col.ctrl[g] && (col.data[8*g +: 8] == TERM_BYTE);
    end

    localparam logic [LANES-1:0] LANE0_ONLY = LANES'(1);

    always_comb begin
        cls.idle  = (&col.ctrl) && (col.data == {LANES{IDLE_BYTE}});
        cls.seq   = (col.ctrl == LANE0_ONLY) && (col.data[7:0] == SEQ_BYTE);
        cls.sig   = (col.ctrl == LANE0_ONLY) && (col.data[7:0] == SIG_BYTE);
        cls.term  = |lane_term;
        cls.start = col.ctrl[0] && (col.data[7:0] == START_BYTE);
    end
endmodule

// File: rtl/rmf_ring.sv
module rmf_ring
    import rmf_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  col_t          push_col,
    output col_t          head_col,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } ring_t;

    ring_t st_q, st_d;
    col_t  mem [DEPTH];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (push) st_d.wp = bump(st_q.wp);
        if (pop)  st_d.rp = bump(st_q.rp);
        st_d.lvl = st_q.lvl + LW'(push) - LW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[st_q.wp] <= push_col;
    end

    assign head_col = mem[st_q.rp];
    assign level    = st_q.lvl;
endmodule

// File: rtl/rmf_sat_cnt.sv
module rmf_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] value
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != {W{1'b1}})) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign value = cnt_q;
endmodule

// File: rtl/rate_match_fifo.sv
module rate_match_fifo
    import rmf_pkg::*;
#(
    parameter  int DEPTH = 16,
    parameter  int CW    = 16,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [31:0]   wr_data,
    input  logic [3:0]    wr_ctrl,
    input  logic          rd_en,
    input  logic [LW-1:0] hi_mark,
    input  logic [LW-1:0] lo_mark,
    output logic          rd_valid,
    output logic [31:0]   rd_data,
    output logic [3:0]    rd_ctrl,
    output logic [LW-1:0] fill,
    output logic [CW-1:0] ins_count,
    output logic [CW-1:0] del_count,
    output logic [CW-1:0] ovf_count,
    output logic [CW-1:0] udf_count
);
    localparam int NEV = 4;

    typedef struct packed {
        logic prot;       // previous written column carried a terminate
        logic seq_keep;   // previous written column was a kept sequence column
        logic last_os;    // last emitted column was idle or ordered set
        logic in_frame;   // start emitted, terminate not yet emitted
        logic rd_valid;
        col_t rd_col;
    } state_t;

    state_t st_q, st_d;

    col_t          wr_col, head_col, emit_col;
    cls_t          wr_cls, head_cls, emit_cls;
    logic [LW-1:0] level;
    logic          del, push, ovf, ins, pop, udf, full, empty;
    logic          wr_removable;
    logic [NEV-1:0] ev;
    logic [CW-1:0]  cnt_val [NEV];

    assign wr_col = '{ctrl: wr_ctrl, data: wr_data};

    rmf_classify u_wr_cls   (.col(wr_col),   .cls(wr_cls));
    rmf_classify u_head_cls (.col(head_col), .cls(head_cls));

    rmf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_col (wr_col),
        .head_col (head_col),
        .level    (level)
    );

    always_comb begin
        full  = (level == LW'(DEPTH));
        empty = (level == '0);

        // idle columns outside the protected slot, or the second of a sequence pair;
        // signal and start columns are never candidates
        wr_removable = ((wr_cls.idle && !st_q.prot) || (wr_cls.seq && st_q.seq_keep))
                       && !wr_cls.sig && !wr_cls.start;
        del  = wr_valid && (level > hi_mark) && wr_removable;
        push = wr_valid && !del && !full;
        ovf  = wr_valid && !del && full;

        ins  = rd_en && (level < lo_mark) && st_q.last_os && !st_q.in_frame;
        pop  = rd_en && !ins && !empty;
        udf  = rd_en && !ins && empty;

        emit_col = pop ? head_col : IDLE_COL;
        emit_cls = pop ? head_cls : '{idle: 1'b1, default: 1'b0};

        st_d          = st_q;
        st_d.rd_valid = rd_en;
        if (wr_valid) begin
            st_d.prot     = wr_cls.term;
            st_d.seq_keep = wr_cls.seq && !del;
        end
        if (rd_en) begin
            st_d.rd_col  = emit_col;
            st_d.last_os = emit_cls.idle || emit_cls.seq || emit_cls.sig;
            if (emit_cls.term)       st_d.in_frame = 1'b0;
            else if (emit_cls.start) st_d.in_frame = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.last_os  <= 1'b1;
            st_q.rd_col   <= IDLE_COL;
        end else begin
            st_q <= st_d;
        end
    end

    assign ev = {udf, ovf, del, ins};

    for (genvar g = 0; g < NEV; g++) begin : g_cnt
        rmf_sat_cnt #(.W(CW)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (ev[g]),
            .value (cnt_val[g])
        );
    end

    assign ins_count = cnt_val[0];
    assign del_count = cnt_val[1];
    assign ovf_count = cnt_val[2];
    assign udf_count = cnt_val[3];

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_col.data;
    assign rd_ctrl  = st_q.rd_col.ctrl;
    assign fill     = level;
endmodule

// File: rtl/rmf_checker.sv
module rmf_checker #(
    parameter  int DEPTH = 16,
    parameter  int CW    = 16,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          rd_en,
    input logic          rd_valid,
    input logic [31:0]   rd_data,
    input logic [3:0]    rd_ctrl,
    input logic [LW-1:0] fill,
    input logic [CW-1:0] ins_count,
    input logic [CW-1:0] del_count,
    input logic [CW-1:0] ovf_count,
    input logic [CW-1:0] udf_count
);
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= LW'(DEPTH)); // R9

    AST_RDVALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(rd_en)); // R2

    AST_FILL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_valid && !rd_en) |=> $stable(fill)); // R2

    AST_DEL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (del_count != $past(del_count)) |-> (fill <= $past(fill) && $past(wr_valid))); // R3

    AST_INS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_count != $past(ins_count)) |-> (rd_ctrl == 4'hF && rd_data == 32'h0707_0707)); // R7

    AST_UDF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (udf_count != $past(udf_count)) |-> (rd_ctrl == 4'hF && rd_data == 32'h0707_0707)); // R10

    AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_count != $past(ovf_count)) |-> ($past(fill) == LW'(DEPTH) && fill >= $past(fill) - LW'(1))); // R9
endmodule

bind rate_match_fifo rmf_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_valid  (wr_valid),
    .rd_en     (rd_en),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_ctrl   (rd_ctrl),
    .fill      (fill),
    .ins_count (ins_count),
    .del_count (del_count),
    .ovf_count (ovf_count),
    .udf_count (udf_count)
);

// File: tb/tb_rate_match_fifo.sv
module tb_rate_match_fifo;
    localparam int DEPTH = 16;
    localparam int CW    = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [3:0]    wr_ctrl = '0;
    logic          rd_en = 1'b0;
    logic [LW-1:0] hi_mark = LW'(8);
    logic [LW-1:0] lo_mark = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [3:0]    rd_ctrl;
    logic [LW-1:0] fill;
    logic [CW-1:0] ins_count, del_count, ovf_count, udf_count;

    always #4 clk = ~clk;

    rate_match_fifo #(.DEPTH(DEPTH), .CW(CW)) dut (.*);

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // column builders
    localparam logic [35:0] C_IDLE = {4'hF, 32'h0707_0707};
    localparam logic [35:0] C_SEQ  = {4'h1, 32'h0000_009C};
    localparam logic [35:0] C_SIG  = {4'h1, 32'h0000_005C};
    localparam logic [35:0] C_STRT = {4'h1, 32'h5555_55FB};
    function automatic logic [35:0] c_data(input int v);
        return {4'h0, 32'(v) ^ 32'hA500_0000};
    endfunction
    function automatic logic [35:0] c_term(input int lane);
        logic [35:0] c;
        for (int i = 0; i < 4; i++) begin
            if (i < lane)       begin c[32+i] = 1'b0; c[8*i +: 8] = 8'(8'h30 + i); end
            else if (i == lane) begin c[32+i] = 1'b1; c[8*i +: 8] = 8'hFD; end
            else                begin c[32+i] = 1'b1; c[8*i +: 8] = 8'h07; end
        end
        return c;
    endfunction

    // reference model
    logic [35:0] mq[$];
    bit  m_prot, m_seqk, m_last_os, m_in_frame, m_rdv;
    logic [35:0] m_rd;
    int  m_ins, m_del, m_ovf, m_udf;

    function automatic bit f_idle(input logic [35:0] c); return c == C_IDLE; endfunction
    function automatic bit f_seq(input logic [35:0] c);  return c[35:32] == 4'h1 && c[7:0] == 8'h9C; endfunction
    function automatic bit f_sig(input logic [35:0] c);  return c[35:32] == 4'h1 && c[7:0] == 8'h5C; endfunction
    function automatic bit f_strt(input logic [35:0] c); return c[32] && c[7:0] == 8'hFB; endfunction
    function automatic bit f_term(input logic [35:0] c);
        bit t = 0;
        for (int i = 0; i < 4; i++) if (c[32+i] && c[8*i +: 8] == 8'hFD) t = 1;
        return t;
    endfunction
    function automatic int sat(input int v); return (v > 65535) ? 65535 : v; endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_prot = 0; m_seqk = 0; m_last_os = 1; m_in_frame = 0; m_rdv = 0;
            m_rd = C_IDLE; m_ins = 0; m_del = 0; m_ovf = 0; m_udf = 0;
        end else begin
            automatic int sz = mq.size();
            automatic logic [35:0] wc = {wr_ctrl, wr_data};
            automatic bit dl = 0;
            automatic bit did_ins = 0;
            if (wr_valid) begin
                dl = (sz > int'(hi_mark)) && ((f_idle(wc) && !m_prot) || (f_seq(wc) && m_seqk));
                if (dl) m_del = sat(m_del + 1);
            end
            m_rdv = rd_en;
            if (rd_en) begin
                automatic logic [35:0] oc;
                if (sz < int'(lo_mark) && m_last_os && !m_in_frame) begin
                    oc = C_IDLE; m_ins = sat(m_ins + 1); did_ins = 1;
                end else if (sz == 0) begin
                    oc = C_IDLE; m_udf = sat(m_udf + 1);
                end else begin
                    oc = mq.pop_front();
                end
                m_rd = oc;
                m_last_os = f_idle(oc) || f_seq(oc) || f_sig(oc);
                if (f_term(oc)) m_in_frame = 0;
                else if (f_strt(oc)) m_in_frame = 1;
            end
            if (wr_valid) begin
                if (!dl) begin
                    if (sz == DEPTH) m_ovf = sat(m_ovf + 1);
                    else mq.push_back(wc);
                end
                m_prot = f_term(wc);
                m_seqk = f_seq(wc) && !dl;
            end
            if (did_ins) begin end
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk(rd_valid == m_rdv, "R2 rd_valid", rd_valid, m_rdv);
            if (m_rdv) chk({rd_ctrl, rd_data} == m_rd, "R2 read column", {rd_ctrl, rd_data}, m_rd);
            chk(int'(fill) == mq.size(), "R2 fill", fill, mq.size());
            chk(int'(ins_count) == m_ins, "R7 ins_count", ins_count, m_ins);
            chk(int'(del_count) == m_del, "R3 del_count", del_count, m_del);
            chk(int'(ovf_count) == m_ovf, "R9 ovf_count", ovf_count, m_ovf);
            chk(int'(udf_count) == m_udf, "R10 udf_count", udf_count, m_udf);
        end
    end

    task automatic step(input bit wv, input logic [35:0] c, input bit re);
        @(negedge clk);
        wr_valid = wv; {wr_ctrl, wr_data} = c; rd_en = re;
    endtask
    task automatic put(input logic [35:0] c); step(1, c, 0); endtask
    task automatic get(); step(0, C_IDLE, 0); rd_en = 1; endtask
    task automatic idle_cyc(); step(0, '0, 0); endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        finish_run();
    end

    initial begin
        int d0, i0, u0, o0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(fill == 0 && rd_valid == 0, "R1 fill/rd_valid after reset", {fill, rd_valid}, 0);
        chk(ins_count == 0 && del_count == 0 && ovf_count == 0 && udf_count == 0,
            "R1 counters after reset", ins_count + del_count + ovf_count + udf_count, 0);

        // R2 plain pass-through
        hi_mark = LW'(8); lo_mark = '0;
        for (int i = 0; i < 4; i++) put(c_data(i));
        for (int i = 0; i < 4; i++) get();
        idle_cyc();
        chk(fill == 0, "R2 drained", fill, 0);

        // R3 idle removal above threshold
        hi_mark = LW'(4);
        for (int i = 0; i < 5; i++) put(c_data(16 + i));
        d0 = del_count;
        for (int i = 0; i < 3; i++) put(C_IDLE);
        idle_cyc();
        chk(fill == 5, "R3 fill after idle removal", fill, 5);
        chk(del_count - d0 == 3, "R3 removed idles", del_count - d0, 3);

        // R4 protected slot after terminate
        d0 = del_count;
        put(c_term(3));
        put(C_IDLE);
        put(C_IDLE);
        idle_cyc();
        chk(fill == 7, "R4 fill after terminate gap", fill, 7);
        chk(del_count - d0 == 1, "R4 only unprotected idle removed", del_count - d0, 1);

        // R5 sequence pairs
        d0 = del_count;
        for (int i = 0; i < 3; i++) put(C_SEQ);
        idle_cyc();
        chk(fill == 9, "R5 fill after three sequence columns", fill, 9);
        chk(del_count - d0 == 1, "R5 one of pair removed", del_count - d0, 1);

        // R6 signal columns kept
        d0 = del_count;
        put(C_SIG); put(C_SIG);
        idle_cyc();
        chk(fill == 11, "R6 signal columns stored", fill, 11);
        chk(del_count == d0, "R6 no removal of signal", del_count - d0, 0);

        lo_mark = '0;
        for (int i = 0; i < 11; i++) get();
        idle_cyc();

        // R7 insertion below low threshold
        lo_mark = LW'(3);
        put(C_IDLE);
        i0 = ins_count;
        get(); get();
        idle_cyc();
        chk(ins_count - i0 == 2, "R7 idles inserted", ins_count - i0, 2);
        chk(fill == 1, "R7 fill held during insertion", fill, 1);
        lo_mark = '0;
        get();
        idle_cyc();

        // R8 no insertion inside a frame, R10 underflow
        put(C_STRT); put(c_data(99));
        get();
        idle_cyc();
        lo_mark = LW'(3);
        i0 = ins_count; u0 = udf_count;
        get(); get();
        idle_cyc();
        chk(ins_count == i0, "R8 no insertion mid-frame", ins_count - i0, 0);
        chk(udf_count - u0 == 1, "R10 underflow counted", udf_count - u0, 1);
        chk({rd_ctrl, rd_data} == C_IDLE, "R10 underflow column", {rd_ctrl, rd_data}, C_IDLE);
        put(c_term(0));
        lo_mark = '0;
        get();
        idle_cyc();

        // R9 overflow
        hi_mark = LW'(DEPTH);
        o0 = ovf_count;
        for (int i = 0; i < DEPTH + 1; i++) put(c_data(200 + i));
        idle_cyc();
        chk(ovf_count - o0 == 1, "R9 overflow counted", ovf_count - o0, 1);
        chk(fill == DEPTH, "R9 fill at depth", fill, DEPTH);
        for (int i = 0; i < DEPTH; i++) get();
        idle_cyc();

        // mixed random traffic against the model
        hi_mark = LW'(10); lo_mark = LW'(4);
        void'($urandom(7));
        for (int i = 0; i < 3000; i++) begin
            automatic int k = $urandom_range(0, 9);
            automatic logic [35:0] c;
            case (k)
                0, 1, 2: c = C_IDLE;
                3:       c = C_SEQ;
                4:       c = C_SIG;
                5:       c = C_STRT;
                6:       c = c_term($urandom_range(0, 3));
                default: c = c_data(i);
            endcase
            step($urandom_range(0, 9) < 6, c, $urandom_range(0, 9) < 5);
        end
        idle_cyc();
        idle_cyc();
        finish_run();
    end
endmodule